// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This block watches the pins of one GPIO bank, made of four ports of eight pins, and turns pin activity into pending interrupt status. Each pin has a three-bit sense setting taken from a 24-bit type word for its port. The setting picks a rising edge, a falling edge, either edge, a high level or a low level. The pin levels arrive already synchronized to the clock. The type words, the enable vector and the clear strobes come from a register block outside this unit.

Each pin has a small two-state machine. In `PIN_IDLE` no event is pending. The transition *trigger* moves it to `PIN_PEND` when the selected edge is seen, or, in level mode, while the selected level is present. From `PIN_PEND`, the transition *acknowledge* returns an edge-mode pin to `PIN_IDLE` when software writes a one to its clear bit and no new edge arrives in the same cycle. The transition *release* returns a level-mode pin to `PIN_IDLE` as soon as its level is no longer active. In all other cases the machine stays in its current state.

The status vector is the set of pins in `PIN_PEND`. A pin's status bit and its enable bit are ANDed, and the results over all four ports are ORed into one bank interrupt.

Top module: `gpio_irq_sense`

## Requirements
- R1: For pin n of port p, type input bit p*24+n is the polarity (1 = high or rising), bit p*24+8+n selects edge mode (1) or level mode (0), and bit p*24+16+n selects both-edge detection in edge mode. The codes for one pin, before the shift by n, are: rising 0x000101, falling 0x000100, both 0x010100, level high 0x000001, level low 0x000000.
- R2: In rising mode, a 0-to-1 change of the pin sets its status bit at the next clock edge. The bit then stays set, through a later 1-to-0 change, until it is cleared.
- R3: In falling mode, a 1-to-0 change sets the status bit at the next clock edge. The bit stays set until it is cleared.
- R4: In both-edge mode, either kind of change sets the status bit at the next clock edge.
- R5: In level mode, the status bit equals the level condition (high mode: pin is 1; low mode: pin is 0) one clock later. A clear has no effect while the condition holds.
- R6: While a port's clear strobe is high, each one bit in the clear data clears the matching pending edge-mode status bit of that port at the next clock edge. Zero bits, and the other ports, are left unchanged.
- R7: An edge that arrives in the same cycle as a clear of that pin leaves the status bit set.
- R8: After a status bit is cleared, a new edge sets it again.
- R9: The bank interrupt is high in the same cycle whenever at least one pin has both its status bit and its enable bit set, and low otherwise. Status bits are visible whether or not the pin is enabled.
- R10: Reset clears all status bits. The edge history follows the pins during reset, so leaving reset with unchanged pins creates no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | 32 | Synchronized pin levels, port p at bits p*8+7..p*8 |
| sense_cfg | input | 96 | Four 24-bit type words, port p at bits p*24+23..p*24 |
| irq_en | input | 32 | Per-pin interrupt enable |
| clr_stb | input | 4 | Per-port clear write strobe |
| clr_data | input | 8 | Write-one-to-clear data for the strobed ports |
| status | output | 32 | Pending status per pin |
| bank_irq | output | 1 | OR of all enabled pending pins |

## Verification
A pin machine stuck in `PIN_PEND` shows up on its status bit in the first cycle after an acknowledge that should have cleared it. A machine that misses a trigger leaves its status bit low one clock after the pin change. A wrong edge history, for example one loaded at reset with a fixed value instead of the pins, produces a pending bit in the first cycle after reset. Faults in the enable combine are visible on the bank interrupt in the same cycle as the enable change, because no register lies on that path.

// File: rtl/gis_pkg.sv
package gis_pkg;

    typedef enum logic {
        PIN_IDLE = 1'b0,
        PIN_PEND = 1'b1
    } pin_state_t;

    typedef struct packed {
        logic both;       // any change counts (edge mode only)
        logic edge_mode;  // 1: edge, 0: level
        logic pol;        // 1: high / rising
    } pin_sense_t;

endpackage

// File: rtl/gis_pin_fsm.sv
module gis_pin_fsm
    import gis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  pin_sense_t sense,
    input  logic       clr,
    output logic       status
);

    pin_state_t state_q, state_d;
    logic       prev_q;
    logic       rise, fall, edge_evt, lvl_active, trigger;

    // History register samples the pin in and out of reset alike, so the
    // first compare after reset sees no change.
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    always_comb begin
        rise       = lvl & ~prev_q;
        fall       = ~lvl & prev_q;
        edge_evt   = sense.both ? (rise | fall) : (sense.pol ? rise : fall);
        lvl_active = sense.pol ? lvl : ~lvl;
        trigger    = sense.edge_mode ? edge_evt : lvl_active;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (trigger) state_d = PIN_PEND;          // trigger
            end
            PIN_PEND: begin
                if (sense.edge_mode) begin
                    if (clr && !edge_evt) state_d = PIN_IDLE;  // acknowledge
                end else if (!lvl_active) begin
                    state_d = PIN_IDLE;                     // release
                end
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        status = (state_q == PIN_PEND);
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense.edge_mode && edge_evt) |=> status);                  // R2
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense.edge_mode && status && !clr) |=> status);           // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense.edge_mode && clr && !edge_evt) |=> !status);        // R6
    AST_CLR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (sense.edge_mode && clr && edge_evt) |=> status);          // R7
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense.edge_mode) |=> (status == $past(lvl_active)));     // R5

endmodule

// File: rtl/gis_port.sv
module gis_port
    import gis_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   lvl,
    input  logic [3*PINS-1:0] cfg,
    input  logic              clr_stb,
    input  logic [PINS-1:0]   clr_data,
    output logic [PINS-1:0]   status
);

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        pin_sense_t sense;
        assign sense.pol       = cfg[n];
        assign sense.edge_mode = cfg[PINS + n];
        assign sense.both      = cfg[2*PINS + n];

        gis_pin_fsm u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (lvl[n]),
            .sense  (sense),
            .clr    (clr_stb & clr_data[n]),
            .status (status[n])
        );
    end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PINS-1:0]     pin_lvl,
    input  logic [NUM_PORTS*3*PINS-1:0]   sense_cfg,
    input  logic [NUM_PORTS*PINS-1:0]     irq_en,
    input  logic [NUM_PORTS-1:0]          clr_stb,
    input  logic [PINS-1:0]               clr_data,
    output logic [NUM_PORTS*PINS-1:0]     status,
    output logic                          bank_irq
);

    localparam int NPINS = NUM_PORTS * PINS;
    localparam int CFG_W = 3 * PINS;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gis_port #(.PINS(PINS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_lvl[p*PINS +: PINS]),
            .cfg      (sense_cfg[p*CFG_W +: CFG_W]),
            .clr_stb  (clr_stb[p]),
            .clr_data (clr_data),
            .status   (status[p*PINS +: PINS])
        );
    end

    logic [NPINS-1:0] armed;
    always_comb begin
        armed    = status & irq_en;
        bank_irq = |armed;
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (irq_en != '0));                               // R9
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0));                           // R10

endmodule

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = 32'hA5A5_A5A5;
    logic [95:0] sense_cfg = '0;
    logic [31:0] irq_en = '0;
    logic [3:0]  clr_stb = '0;
    logic [7:0]  clr_data = '0;
    logic [31:0] status;
    logic        bank_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_irq_sense u_gpio_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sense_cfg(sense_cfg),
        .irq_en(irq_en), .clr_stb(clr_stb), .clr_data(clr_data),
        .status(status), .bank_irq(bank_irq)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_port(input int p, input logic [23:0] w);
        sense_cfg[p*24 +: 24] = w;
    endtask

    task automatic pulse_clr(input int p, input logic [7:0] d);
        clr_stb[p] = 1'b1;
        clr_data   = d;
        step();
        clr_stb  = '0;
        clr_data = '0;
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) set_port(p, 24'h00FFFF);  // rising
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R10 status after reset", status == 32'h0, 1'b1);
        step();
        check("R10 no edge from reset", status == 32'h0, 1'b1);
        check("R9 irq idle", bank_irq, 1'b0);
    endtask

    task automatic t_rising();
        pin_lvl[11] = 1'b1; step();
        check("R2 rise sets", status[11], 1'b1);
        check("R1 neighbour untouched", status[10], 1'b0);
        step();
        check("R2 holds", status[11], 1'b1);
        pin_lvl[11] = 1'b0; step();
        check("R2 fall ignored", status[11], 1'b1);
        pulse_clr(1, 8'h08);
        check("R6 clear", status[11], 1'b0);
    endtask

    task automatic t_falling();
        set_port(2, 24'h00FF00);
        step();
        check("R3 no event yet", status[16], 1'b0);
        pin_lvl[16] = 1'b0; step();
        check("R3 fall sets", status[16], 1'b1);
        pulse_clr(2, 8'h02);
        check("R6 zero bit no effect", status[16], 1'b1);
        pulse_clr(0, 8'h01);
        check("R6 other port no effect", status[16], 1'b1);
        pulse_clr(2, 8'h01);
        check("R6 clear falling", status[16], 1'b0);
        pin_lvl[16] = 1'b1; step();
        check("R3 rise ignored", status[16], 1'b0);
    endtask

    task automatic t_both();
        set_port(3, 24'hFFFF00);
        step();
        pin_lvl[24] = 1'b0; step();
        check("R4 fall sets", status[24], 1'b1);
        pulse_clr(3, 8'h01);
        check("R4 cleared", status[24], 1'b0);
        pin_lvl[24] = 1'b1; step();
        check("R4 rise sets", status[24], 1'b1);
        pulse_clr(3, 8'h01);
    endtask

    task automatic t_level();
        set_port(0, 24'h0000FF);  // level high
        step();
        check("R5 high idle", status[1], 1'b0);
        check("R5 high active pin", status[0], 1'b1);
        pin_lvl[1] = 1'b1; step();
        check("R5 high follows", status[1], 1'b1);
        pulse_clr(0, 8'h02);
        check("R5 clear no effect", status[1], 1'b1);
        pin_lvl[1] = 1'b0; step();
        check("R5 release", status[1], 1'b0);
        set_port(0, 24'h000000);  // level low
        step();
        check("R5 low follows", status[1], 1'b1);
        pin_lvl[1] = 1'b1; step();
        check("R5 low release", status[1], 1'b0);
    endtask

    task automatic t_race();
        pin_lvl[12] = 1'b1; step();
        check("R2 pin12 set", status[12], 1'b1);
        pin_lvl[12] = 1'b0; step();
        pin_lvl[12] = 1'b1;
        pulse_clr(1, 8'h10);
        check("R7 edge beats clear", status[12], 1'b1);
        pulse_clr(1, 8'h10);
        check("R8 cleared", status[12], 1'b0);
        pin_lvl[12] = 1'b0; step();
        pin_lvl[12] = 1'b1; step();
        check("R8 re-arm", status[12], 1'b1);
    endtask

    task automatic t_irq();
        check("R9 pending but disabled", bank_irq, 1'b0);
        irq_en[12] = 1'b1; #2;
        check("R9 enable asserts at once", bank_irq, 1'b1);
        step();
        pulse_clr(1, 8'h10);
        check("R9 clear drops irq", bank_irq, 1'b0);
        check("R9 status visible", status[1], 1'b0);
        irq_en[16] = 1'b1; #2;
        check("R9 idle pin enabled", bank_irq, 1'b0);
        irq_en[1] = 1'b1; #2;  // port 0 pin1 is level-low, pin at 1: idle
        check("R9 idle level pin", bank_irq, 1'b0);
        irq_en[3] = 1'b1; #2;  // pin3 low under level low: pending
        check("R9 level pin raises irq", bank_irq, 1'b1);
    endtask

    initial begin
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level();
        t_race();
        t_irq();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule